// File: doc/BRIEF.md
# Masked PCI Configuration Register File

This block holds a 256-byte configuration space of the kind a PCI function exposes to its host. Software writes arrive as a dword address, 32 bits of data and four byte enables; every enabled byte is combined with its stored value through a fixed per-offset writable-bit mask. The effect is that read-only and reserved bits never change, whatever software writes.

The status high byte is the one exception to the plain mask merge. Its writable bits are write-one-to-clear: a 1 written to one of them clears it, and a 0 leaves it alone. The mask applies only inside the 64-byte standard header. Everything from offset 0x40 upward is stored exactly as written. Reads are combinational and return the stored dword at the read address. At reset the whole store is loaded from a parameterised image.

Top module: `cfg_space_regfile`

## Requirements
- R1: While `rst_n` is low, every byte is loaded from `INIT_IMAGE`. Byte n sits at bits [8n+7:8n]. The default image holds these values: bytes 0x00..0x03 are D1 C3 42 7E. Byte 0x06 is 0x10 and byte 0x07 is 0xFF. Bytes 0x08..0x0B are 03 00 80 03. Bytes 0x2C..0x2F are 11 22 33 44 and byte 0x3D is 0x01. Every other header byte is zero. Each byte n at or above 0x40 holds n XOR 0x5A.
- R2: `rd_data` shows the dword at `rd_addr` with no clock edge needed. Byte 4*`rd_addr`+k appears on bits [8k+7:8k].
- R3: A byte changes only when `wr_en` is high and its lane enable `wr_be[k]` is set. The byte targeted is 4*`wr_addr`+k. The change is visible from the next clock edge.
- R4: For a masked header byte, the new value is (old AND NOT mask) OR (data AND mask).
- R5: Command bytes: offset 0x04 has mask 0xFF and offset 0x05 has mask 0x07.
- R6: Status low byte 0x06 has mask 0x00 and is never changed by a write.
- R7: Status high byte 0x07 has mask 0xF9. Writing 1 to a masked bit clears it, and writing 0 leaves it unchanged. Bits 1 and 2 are read-only.
- R8: The cache line byte 0x0C and the interrupt line byte 0x3C are fully writable.
- R9: Bytes 0x10..0x27 are fully writable.
- R10: The expansion ROM bytes 0x30, 0x31, 0x32 and 0x33 have masks 0x01, 0xF8, 0xFF and 0xFF respectively.
- R11: All other header bytes below 0x40 have mask 0x00, so writes leave them unchanged.
- R12: Bytes 0x40..0xFF take the written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the image |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Dword address of the write |
| wr_data | input | 32 | Write data, lane k on bits [8k+7:8k] |
| wr_be | input | 4 | Byte lane enables |
| rd_addr | input | 6 | Dword address of the read |
| rd_data | output | 32 | Stored dword at `rd_addr` |

## Verification
The assertions assume the write and read inputs are known, never X, whenever reset is released. The read-after-write properties only make a claim when `rd_addr` is the same on two successive clock edges. When the read address moves, they pass vacuously. The bench changes every input only on the falling edge and keeps `rd_addr` fixed through each write. As a result, the status, lane-enable and extended-region properties are actually exercised, rather than only passing vacuously.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam int unsigned HDR_BYTES   = 64;
    localparam int unsigned IMG_BYTES   = 256;
    localparam int unsigned W1C_OFFSET  = 8'h07;

    // writable-bit mask of one configuration byte
    function automatic logic [7:0] wmask_of(input int unsigned off);
        logic [7:0] m;
        if (off >= HDR_BYTES) begin
            m = 8'hFF;
        end else if (off >= 32'h10 && off <= 32'h27) begin
            m = 8'hFF;
        end else begin
            unique case (off)
                32'h04:  m = 8'hFF;
                32'h05:  m = 8'h07;
                32'h07:  m = 8'hF9;
                32'h0C:  m = 8'hFF;
                32'h30:  m = 8'h01;
                32'h31:  m = 8'hF8;
                32'h32:  m = 8'hFF;
                32'h33:  m = 8'hFF;
                32'h3C:  m = 8'hFF;
                default: m = 8'h00;
            endcase
        end
        return m;
    endfunction

    function automatic logic is_w1c(input int unsigned off);
        return off == W1C_OFFSET;
    endfunction

    function automatic logic [7:0] image_byte(input int unsigned off);
        logic [7:0] v;
        if (off >= HDR_BYTES) begin
            v = 8'(off) ^ 8'h5A;
        end else begin
            unique case (off)
                32'h00:  v = 8'hD1;
                32'h01:  v = 8'hC3;
                32'h02:  v = 8'h42;
                32'h03:  v = 8'h7E;
                32'h06:  v = 8'h10;
                32'h07:  v = 8'hFF;
                32'h08:  v = 8'h03;
                32'h0A:  v = 8'h80;
                32'h0B:  v = 8'h03;
                32'h2C:  v = 8'h11;
                32'h2D:  v = 8'h22;
                32'h2E:  v = 8'h33;
                32'h2F:  v = 8'h44;
                32'h3D:  v = 8'h01;
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    function automatic logic [IMG_BYTES*8-1:0] default_image();
        logic [IMG_BYTES*8-1:0] img;
        for (int i = 0; i < IMG_BYTES; i++) begin
            img[i*8 +: 8] = image_byte(i);
        end
        return img;
    endfunction

endpackage

// File: rtl/cfg_wmask_lookup.sv
module cfg_wmask_lookup #(
    parameter int OFF_W = 8
) (
    input  logic [OFF_W-1:0] offset,
    output logic [7:0]       mask,
    output logic             w1c
);
    always_comb begin
        mask = cfgspace_pkg::wmask_of(int'(offset));
        w1c  = cfgspace_pkg::is_w1c(int'(offset));
    end
endmodule

// File: rtl/cfg_byte_merge.sv
module cfg_byte_merge (
    input  logic [7:0] old_byte,
    input  logic [7:0] wr_byte,
    input  logic [7:0] mask,
    input  logic       w1c,
    output logic [7:0] new_byte
);
    logic [7:0] hit;
    logic [7:0] upd;

    always_comb begin
        hit = wr_byte & mask;
        if (w1c) begin
            upd = (~hit & old_byte) & mask;
        end else begin
            upd = hit;
        end
        new_byte = (old_byte & ~mask) | upd;
    end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter logic [(LANES<<ADDR_W)*8-1:0] INIT_IMAGE = cfgspace_pkg::default_image()
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [LANES*8-1:0]   wr_data,
    input  logic [LANES-1:0]     wr_be,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [LANES*8-1:0]   rd_data
);
    localparam int LANE_W = $clog2(LANES);
    localparam int OFF_W  = ADDR_W + LANE_W;
    localparam int BYTES  = LANES << ADDR_W;

    logic [7:0] store [BYTES];
    logic [7:0] merged [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [LANE_W-1:0] LI = l[LANE_W-1:0];
        logic [OFF_W-1:0] w_off;
        logic [7:0]       lane_mask;
        logic             lane_w1c;

        assign w_off = {wr_addr, LI};

        cfg_wmask_lookup #(.OFF_W(OFF_W)) u_mask (
            .offset (w_off),
            .mask   (lane_mask),
            .w1c    (lane_w1c)
        );

        cfg_byte_merge u_merge (
            .old_byte (store[w_off]),
            .wr_byte  (wr_data[8*l +: 8]),
            .mask     (lane_mask),
            .w1c      (lane_w1c),
            .new_byte (merged[l])
        );

        assign rd_data[8*l +: 8] = store[{rd_addr, LI}];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                store[i] <= INIT_IMAGE[i*8 +: 8];
            end
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_be[l]) begin
                    store[{wr_addr, LANE_W'(l)}] <= merged[l];
                end
            end
        end
    end
endmodule

// File: rtl/cfg_space_regfile_chk.sv
module cfg_space_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [5:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [3:0]  wr_be,
    input logic [5:0]  rd_addr,
    input logic [31:0] rd_data
);
    // no write -> dword at a held read address stays
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));

    // disabled lane 2 of the written dword keeps its value
    assert_lane_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[2] && rd_addr == wr_addr) |=>
        (rd_addr != $past(rd_addr)) || (rd_data[23:16] == $past(rd_data[23:16])));

    // status low byte never changes on write
    assert_status_lo_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 6'd1 && rd_addr == 6'd1) |=>
        (rd_addr != 6'd1) || (rd_data[23:16] == $past(rd_data[23:16])));

    // status high byte: no bit can become set by a write
    assert_status_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 6'd1 && wr_be[3] && rd_addr == 6'd1) |=>
        (rd_addr != 6'd1) || ((rd_data[31:24] & ~$past(rd_data[31:24])) == 8'h00));

    // status high byte: bits written as 1 in the mask end up clear
    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 6'd1 && wr_be[3] && rd_addr == 6'd1) |=>
        (rd_addr != 6'd1) || ((rd_data[31:24] & $past(wr_data[31:24]) & 8'hF9) == 8'h00));

    // extended region takes data as written
    assert_ext_direct_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 6'd16 && wr_be[0] && rd_addr == wr_addr) |=>
        (rd_addr != $past(rd_addr)) || (rd_data[7:0] == $past(wr_data[7:0])));
endmodule

bind cfg_space_regfile cfg_space_regfile_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/sim_cfg_space_regfile.sv
module sim_cfg_space_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    cfg_space_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // expected reset image (R1)
    function automatic logic [7:0] exp_init(input int n);
        logic [7:0] t [64];
        for (int i = 0; i < 64; i++) t[i] = 8'h00;
        t[0] = 8'hD1; t[1] = 8'hC3; t[2] = 8'h42; t[3] = 8'h7E;
        t[6] = 8'h10; t[7] = 8'hFF;
        t[8] = 8'h03; t[10] = 8'h80; t[11] = 8'h03;
        t[44] = 8'h11; t[45] = 8'h22; t[46] = 8'h33; t[47] = 8'h44;
        t[61] = 8'h01;
        if (n >= 64) return 8'(n) ^ 8'h5A;
        return t[n];
    endfunction

    // writable masks from R5, R6, R7, R8, R9, R10, R11, R12
    function automatic logic [7:0] exp_mask(input int n);
        if (n >= 64) return 8'hFF;
        if (n >= 16 && n <= 39) return 8'hFF;
        case (n)
            4: return 8'hFF;
            5: return 8'h07;
            7: return 8'hF9;
            12: return 8'hFF;
            48: return 8'h01;
            49: return 8'hF8;
            50: return 8'hFF;
            51: return 8'hFF;
            60: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] model_dword(input int a);
        return {model[4*a+3], model[4*a+2], model[4*a+1], model[4*a]};
    endfunction

    task automatic apply_model(input int a, input logic [31:0] d, input logic [3:0] be);
        for (int k = 0; k < 4; k++) begin
            if (be[k]) begin
                int n = 4*a + k;
                logic [7:0] m = exp_mask(n);
                logic [7:0] b = d[8*k +: 8];
                if (n == 7) model[n] = model[n] & ~(b & m);
                else        model[n] = (model[n] & ~m) | (b & m);
            end
        end
    endtask

    task automatic check_dword(input int a, input string req);
        logic [31:0] e;
        @(negedge clk);
        rd_addr = 6'(a);
        #1;
        e = model_dword(a);
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s dword %0d actual %h expected %h", req, a, rd_data, e);
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        rd_addr = 6'(a);
        wr_addr = 6'(a); wr_data = d; wr_be = be; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        apply_model(a, d, be);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 256; i++) model[i] = exp_init(i);
        // R1 and R2: read every dword without a write in between
        for (int a = 0; a < 64; a++) begin
            rd_addr = 6'(a);
            #1;
            n_chk++;
            if (rd_data !== model_dword(a)) begin
                n_bad++;
                $display("FAIL R1/R2 dword %0d actual %h expected %h", a, rd_data, model_dword(a));
            end
        end
    endtask

    task automatic t_command();
        do_write(1, 32'hFFFF_FFFF, 4'b0011); check_dword(1, "R5");
        do_write(1, 32'h0000_0000, 4'b0011); check_dword(1, "R5 R4");
        do_write(1, 32'h0000_05AA, 4'b0011); check_dword(1, "R4");
    endtask

    task automatic t_status();
        do_write(1, 32'h00FF_0000, 4'b0100); check_dword(1, "R6");
        do_write(1, 32'h0000_0000, 4'b1000); check_dword(1, "R7 zero");
        do_write(1, 32'h0100_0000, 4'b1000); check_dword(1, "R7 one bit");
        do_write(1, 32'hFFFF_FFFF, 4'b1100); check_dword(1, "R7 all");
    endtask

    task automatic t_enables();
        do_write(5, 32'hA1B2_C3D4, 4'b0101); check_dword(5, "R3 lanes");
        @(negedge clk);
        wr_addr = 6'd5; wr_data = 32'h1234_5678; wr_be = 4'hF; wr_en = 1'b0;
        @(negedge clk);
        check_dword(5, "R3 no strobe");
    endtask

    task automatic t_bars();
        for (int a = 4; a < 10; a++) begin
            do_write(a, 32'h0F1E_2D3C ^ (32'(a) * 32'h0101_0101), 4'hF);
            check_dword(a, "R9");
        end
    endtask

    task automatic t_lines();
        do_write(3, 32'hFFFF_FF5C, 4'hF);  check_dword(3, "R8 R11");
        do_write(15, 32'hFFFF_FF77, 4'hF); check_dword(15, "R8 R11");
    endtask

    task automatic t_rom();
        do_write(12, 32'hFFFF_FFFF, 4'hF); check_dword(12, "R10");
        do_write(12, 32'h0000_0000, 4'hF); check_dword(12, "R10");
    endtask

    task automatic t_readonly();
        int ro [6] = '{0, 2, 10, 11, 13, 14};
        foreach (ro[i]) begin
            do_write(ro[i], 32'hFFFF_FFFF, 4'hF);
            check_dword(ro[i], "R11");
        end
    endtask

    task automatic t_ext();
        do_write(16, 32'hDEAD_BEEF, 4'hF); check_dword(16, "R12");
        do_write(40, 32'h0102_0304, 4'b1010); check_dword(40, "R12 R3");
        do_write(63, 32'h0000_0000, 4'hF); check_dword(63, "R12");
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #20;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_command();
        t_status();
        t_enables();
        t_bars();
        t_lines();
        t_rom();
        t_readonly();
        t_ext();
        check_dword(0, "R1 R11");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule